// File: doc/BRIEF.md
# Dual-Reload PWM Down-Counter Timer

This block is a down-counting PWM timer with two reload values. The counter advances on a count tick that a programmable divider derives from the system clock. One phase of the output wave comes from reload A. The other phase comes from reload B, which is read through a shadow copy. Each underflow ends a phase. The counter first wraps to all ones, and on the next count tick it reloads from the value for the phase that follows, minus one. During reload A phases the output is high, and during reload B phases it is low. Software can change the wave period at any time, but a new B value takes effect only at a phase boundary. This keeps every period consistent.

Counting starts from a control-register write or from an external start pulse. It stops only from a control-register write. When a reload value of zero is seen, the wave is held at a constant level so that 0% and 100% duty can be produced. A one-cycle trigger for neighbouring timers fires at the underflow itself. The output change and the interrupt/DMA request come one count tick later, after the duty check has been made.

Top module: `pwm_dual_reload_timer`

## Requirements
- R1: After reset, pwm_out, req_pulse and trig_out are 0, the timer is stopped, and the counter reads 0.
- R2: Count ticks come every P+1 system clocks, where P is the prescale field (control bits 15:8). With nonzero reloads A and B, each high phase lasts (A+1)*(P+1) clocks and each low phase lasts (B+1)*(P+1) clocks.
- R3: Writing control bit 0 as 1, or pulsing ext_start while stopped, starts the timer. In the cycle after the start edge, the counter reads A-1 and pwm_out is high. The start also copies B into the shadow copy.
- R4: When the counter steps from 0, it reads 0xFFFF, and trig_out pulses for exactly that one clock.
- R5: The reload happens on the next count tick after the underflow, which is P+1 clocks after trig_out. At the reload, req_pulse pulses for one clock, pwm_out takes its new level, and the counter takes the next phase's reload value minus 1.
- R6: The shadow copy of B is refreshed only on entry to a high phase. A B write made during a high phase first shows in the low phase after the next one.
- R7: A control write that clears bit 0 in the same clock as an ext_start pulse stops the timer.
- R8: While the timer is stopped, the counter and pwm_out hold their values.
- R9: If the shadow B is 0, pwm_out stays high. Otherwise, if A is 0, pwm_out stays low. A zero reload loads 0, so that phase lasts two count ticks.
- R10: Reads are combinational. Address 0 returns the control word (prescale in bits 15:8, run in bit 0). Address 1 returns A, address 2 returns B, and address 3 returns the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data |
| ext_start | input | 1 | External start pulse |
| pwm_out | output | 1 | PWM wave |
| req_pulse | output | 1 | Interrupt/DMA request, one clock per reload |
| trig_out | output | 1 | Start trigger for other timers, one clock per underflow |

## Verification
The assertions check several rules on every cycle. trig_out only appears while the counter holds all ones and never lasts two clocks. It never coincides with req_pulse. pwm_out changes only at a reload or right after a start. A stop write takes priority over ext_start. The wave timing, shadow-copy ordering, duty extremes and hold-while-stopped behaviour are checked by the bench. It sweeps prescale and reload values and measures phase lengths and trigger-to-request gaps, and compares them with arithmetic expectations.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
   localparam int ADDR_W   = 2;
   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_RELA = 2'd1;
   localparam logic [ADDR_W-1:0] A_RELB = 2'd2;
   localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;
   localparam int PS_LSB   = 8;

   typedef enum logic { PH_A = 1'b0, PH_B = 1'b1 } phase_t;
endpackage

// File: rtl/pdr_prescaler.sv
module pdr_prescaler #(
   parameter int PW = 8,
   parameter bit USE_PRESCALER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          start,
   input  logic [PW-1:0] presc,
   output logic          tick
);
   generate
      if (USE_PRESCALER) begin : g_div
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 pcnt <= '0;
            else if (start || !run)     pcnt <= '0;
            else if (pcnt == presc)     pcnt <= '0;
            else                        pcnt <= pcnt + 1'b1;
         end
         assign tick = run && (pcnt == presc);
      end else begin : g_bypass
         logic unused_presc;
         assign unused_presc = ^{presc, start};
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/pdr_regs.sv
module pdr_regs
   import pdr_pkg::*;
#(
   parameter int CW = 16,
   parameter int PW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              ext_start,
   input  logic [CW-1:0]     cnt,
   output logic [CW-1:0]     rd_data,
   output logic              run_q,
   output logic              start,
   output logic [PW-1:0]     presc,
   output logic [CW-1:0]     rel_a,
   output logic [CW-1:0]     rel_b
);
   logic run_nxt;
   logic ctrl_wr;

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   always_comb begin
      if (ctrl_wr)        run_nxt = wr_data[0];
      else if (ext_start) run_nxt = 1'b1;
      else                run_nxt = run_q;
   end

   assign start = run_nxt && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         presc <= '0;
         rel_a <= '0;
         rel_b <= '0;
      end else begin
         run_q <= run_nxt;
         if (ctrl_wr) presc <= wr_data[PS_LSB +: PW];
         if (wr_en && wr_addr == A_RELA) rel_a <= wr_data;
         if (wr_en && wr_addr == A_RELB) rel_b <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL: begin
            rd_data[PS_LSB +: PW] = presc;
            rd_data[0]            = run_q;
         end
         A_RELA: rd_data = rel_a;
         A_RELB: rd_data = rel_b;
         default: rd_data = cnt;
      endcase
   end
endmodule

// File: rtl/pdr_core.sv
module pdr_core
   import pdr_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          tick,
   input  logic [CW-1:0] rel_a,
   input  logic [CW-1:0] rel_b,
   output logic [CW-1:0] cnt,
   output logic          pwm,
   output logic          req,
   output logic          trig
);
   phase_t        phase;
   logic          uf_pend;
   logic [CW-1:0] b_shadow;

   function automatic logic [CW-1:0] load_val(input logic [CW-1:0] v);
      return (v == '0) ? '0 : v - 1'b1;
   endfunction

   function automatic logic level(input phase_t ph, input logic [CW-1:0] bv,
                                  input logic [CW-1:0] av);
      if (bv == '0)      return 1'b1;
      else if (av == '0) return 1'b0;
      else               return (ph == PH_A);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         phase    <= PH_A;
         uf_pend  <= 1'b0;
         b_shadow <= '0;
         pwm      <= 1'b0;
         req      <= 1'b0;
         trig     <= 1'b0;
      end else begin
         req  <= 1'b0;
         trig <= 1'b0;
         if (start) begin
            cnt      <= load_val(rel_a);
            phase    <= PH_A;
            uf_pend  <= 1'b0;
            b_shadow <= rel_b;
            pwm      <= level(PH_A, rel_b, rel_a);
         end else if (tick) begin
            if (uf_pend) begin
               uf_pend <= 1'b0;
               req     <= 1'b1;
               if (phase == PH_A) begin
                  cnt   <= load_val(b_shadow);
                  phase <= PH_B;
                  pwm   <= level(PH_B, b_shadow, rel_a);
               end else begin
                  cnt      <= load_val(rel_a);
                  phase    <= PH_A;
                  b_shadow <= rel_b;
                  pwm      <= level(PH_A, rel_b, rel_a);
               end
            end else if (cnt == '0) begin
               cnt     <= '1;
               uf_pend <= 1'b1;
               trig    <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pwm_dual_reload_timer.sv
module pwm_dual_reload_timer
   import pdr_pkg::*;
#(
   parameter int CW = 16,
   parameter int PW = 8,
   parameter bit USE_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CW-1:0]     rd_data,
   input  logic              ext_start,
   output logic              pwm_out,
   output logic              req_pulse,
   output logic              trig_out
);
   generate
      if (CW < 4)            begin : g_bad_cw $error("CW too small"); end
      if (PW < 1)            begin : g_bad_pw $error("PW must be at least 1"); end
      if (PS_LSB + PW > CW)  begin : g_bad_fit $error("prescale field does not fit"); end
   endgenerate

   logic          run_q;
   logic          start;
   logic          tick;
   logic [PW-1:0] presc;
   logic [CW-1:0] rel_a;
   logic [CW-1:0] rel_b;
   logic [CW-1:0] cnt;

   pdr_regs #(.CW(CW), .PW(PW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .ext_start(ext_start),
      .cnt(cnt), .rd_data(rd_data), .run_q(run_q), .start(start),
      .presc(presc), .rel_a(rel_a), .rel_b(rel_b)
   );

   pdr_prescaler #(.PW(PW), .USE_PRESCALER(USE_PRESCALER)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run_q), .start(start),
      .presc(presc), .tick(tick)
   );

   pdr_core #(.CW(CW)) u_core (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
      .rel_a(rel_a), .rel_b(rel_b), .cnt(cnt), .pwm(pwm_out),
      .req(req_pulse), .trig(trig_out)
   );
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker
   import pdr_pkg::*;
#(
   parameter int CW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_bit0,
   input logic              ext_start,
   input logic              pwm_out,
   input logic              req_pulse,
   input logic              trig_out,
   input logic [CW-1:0]     cnt,
   input logic              run_q
);
   // R4: trigger only while the counter holds all ones
   a_r4_trig_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> (cnt == {CW{1'b1}}));

   // R4: trigger lasts one clock
   a_r4_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |=> !trig_out);

   // R5: request comes a tick after the trigger, never with it
   a_r5_req_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig_out && req_pulse));

   // R5: after a reload the counter has left the wrap value
   a_r5_req_reloaded: assert property (@(posedge clk) disable iff (!rst_n)
      req_pulse |-> (cnt != {CW{1'b1}}));

   // R5/R3: the wave changes only at a reload or after a start source
   a_r5_pwm_change_src: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwm_out) |-> (req_pulse || $past(wr_en) || $past(ext_start)));

   // R7: a stop write wins over an external start
   a_r7_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL && !wr_bit0 && ext_start) |=> !run_q);

   // R8: a stopped timer keeps its counter and wave
   a_r8_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && $past(!run_q)) |-> ($stable(cnt) && $stable(pwm_out)));
endmodule

bind pwm_dual_reload_timer pdr_checker #(.CW(CW)) u_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_bit0(wr_data[0]), .ext_start(ext_start), .pwm_out(pwm_out),
   .req_pulse(req_pulse), .trig_out(trig_out), .cnt(cnt), .run_q(run_q)
);

// File: tb/pwm_dual_reload_timer_tb.sv
module pwm_dual_reload_timer_tb;
   localparam int CW = 16;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [1:0] rd_addr = 2'd3;
   logic [CW-1:0] rd_data;
   logic ext_start = 1'b0;
   logic pwm_out, req_pulse, trig_out;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pwm_dual_reload_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ext_start(ext_start), .pwm_out(pwm_out), .req_pulse(req_pulse),
      .trig_out(trig_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_pwm(input logic lvl);
      int n = 0;
      while (pwm_out !== lvl && n < 20000) begin @(negedge clk); n++; end
      if (n >= 20000) check("timeout", 0, 1);
   endtask

   task automatic run_len(input logic lvl, output int n);
      n = 0;
      while (pwm_out === lvl && n < 20000) begin @(negedge clk); n++; end
   endtask

   task automatic setup(input int p, input int a, input int b);
      wr(2'd0, 16'h0000);
      wr(2'd1, CW'(a));
      wr(2'd2, CW'(b));
      wr(2'd0, CW'((p << 8) | 1));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int lo, hi, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pwm", pwm_out, 0);
      check("R1 req", req_pulse, 0);
      check("R1 trig", trig_out, 0);
      check("R1 cnt", rd_data, 0);
      rd_addr = 2'd0;
      #0 check("R1 run", rd_data[0], 0);
      rd_addr = 2'd3;

      // R10 readback
      wr(2'd1, 16'h1234); wr(2'd2, 16'h00AB); wr(2'd0, 16'h0500);
      rd_addr = 2'd1; #1 check("R10 relA", rd_data, 16'h1234);
      rd_addr = 2'd2; #1 check("R10 relB", rd_data, 16'h00AB);
      rd_addr = 2'd0; #1 check("R10 ctrl", rd_data, 16'h0500);
      rd_addr = 2'd3;

      // R3 start by write: counter A-1, pwm high
      wr(2'd1, 16'd9); wr(2'd2, 16'd4); wr(2'd0, 16'h0001);
      check("R3 cnt after start", rd_data, 8);
      check("R3 pwm after start", pwm_out, 1);

      // R2 sweep of prescale and reloads
      for (int p = 0; p < 3; p++) begin
         for (int ai = 0; ai < 3; ai++) begin
            for (int bi = 0; bi < 2; bi++) begin
               int a = (ai == 0) ? 1 : (ai == 1) ? 2 : 5;
               int b = (bi == 0) ? 1 : 3;
               setup(p, a, b);
               wait_pwm(1'b0);
               run_len(1'b0, lo);
               run_len(1'b1, hi);
               check($sformatf("R2 low p=%0d b=%0d", p, b), lo, (b + 1) * (p + 1));
               check($sformatf("R2 high p=%0d a=%0d", p, a), hi, (a + 1) * (p + 1));
            end
         end
      end

      // R4/R5 trigger, wrap value, request gap, reload value
      for (int p = 0; p < 4; p += 3) begin
         setup(p, 4, 4);
         n = 0;
         while (!trig_out && n < 5000) begin @(negedge clk); n++; end
         check("R4 cnt at trig", rd_data, 16'hFFFF);
         @(negedge clk);
         check("R4 trig one clock", trig_out, 0);
         n = 1;
         while (!req_pulse && n < 5000) begin @(negedge clk); n++; end
         check($sformatf("R5 gap p=%0d", p), n, p + 1);
         check("R5 cnt after reload", rd_data, 3);
         @(negedge clk);
         check("R5 req one clock", req_pulse, 0);
      end

      // R6 shadow copy ordering
      setup(0, 5, 7);
      wait_pwm(1'b0); wait_pwm(1'b1);
      @(negedge clk);
      wr(2'd2, 16'd3);
      wait_pwm(1'b0);
      run_len(1'b0, lo);
      check("R6 next low keeps old B", lo, 8);
      run_len(1'b1, hi);
      check("R6 high", hi, 6);
      run_len(1'b0, lo);
      check("R6 later low uses new B", lo, 4);

      // R8 hold while stopped
      wr(2'd0, 16'h0000);
      n = rd_data; hi = pwm_out;
      repeat (20) @(negedge clk);
      check("R8 cnt held", rd_data, n);
      check("R8 pwm held", pwm_out, hi);

      // R3 external start
      wr(2'd1, 16'd6);
      @(negedge clk); ext_start = 1'b1;
      @(negedge clk); ext_start = 1'b0;
      check("R3 ext start cnt", rd_data, 5);
      check("R3 ext start pwm", pwm_out, 1);

      // R7 stop write with ext_start in same clock
      repeat (3) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0000; ext_start = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; ext_start = 1'b0;
      n = rd_data;
      repeat (10) @(negedge clk);
      check("R7 counter stopped", rd_data, n);
      rd_addr = 2'd0; #1 check("R7 run bit", rd_data[0], 0);
      rd_addr = 2'd3;

      // R9 duty extremes
      setup(0, 3, 0);
      n = 0;
      repeat (60) begin @(negedge clk); if (pwm_out !== 1'b1) n++; end
      check("R9 B zero holds high", n, 0);
      setup(0, 0, 3);
      n = 0;
      repeat (60) begin @(negedge clk); if (pwm_out !== 1'b0) n++; end
      check("R9 A zero holds low", n, 0);
      // zero phase lasts two ticks: period A0 + B3 = 2 + 4 ticks between alternate requests
      n = 0;
      while (!req_pulse && n < 100) begin @(negedge clk); n++; end
      @(negedge clk);
      n = 1;
      while (!req_pulse && n < 100) begin @(negedge clk); n++; end
      lo = n;
      @(negedge clk);
      n = 1;
      while (!req_pulse && n < 100) begin @(negedge clk); n++; end
      check("R9 zero phase plus other phase", lo + n, 6);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule